// File: doc/BRIEF.md
# Programmable M/N Fractional Clock Divider

This block derives a slower clock from its parent clock at a rate of parent × N / (INT × N + M), so that each output period averages INT + M/N parent cycles. Software programs two 32-bit registers. The fraction register holds the pair M and N. The integer register holds the whole part INT and a reload strobe. All values written land in shadow storage first. The divider only adopts them when the reload strobe is driven from zero to one. Because of this, a new rate always takes effect as one complete set, and the divider never runs on a mix of old and new values.

Inside the block, an accumulator spreads the fraction over the periods. On every period it adds M. Whenever the total reaches N, it subtracts N and makes that one period a single parent cycle longer. Each period starts high and stays high for half its length, rounded down, then goes low for the rest. A set that cannot produce a defined waveform holds the output low. Examples are a whole part below two, a zero denominator, or a numerator that is not smaller than the denominator.

To change the rate, write the fraction register, then write the integer register with the reload bit set, then clear the reload bit with a later write.

Top module: `mn_frac_clkdiv`

## Requirements
- R1: After reset, clk_out is low and both registers read back as zero.
- R2: Reads return the shadow contents. With reg_sel=0 (fraction register, offset 0), M is in bits 15:0 and N is in bits 31:16. With reg_sel=1 (integer register, offset 4), INT is in bits 15:0 and the reload bit is in bit 16, which reads back exactly as last written. All other bits read zero.
- R3: A write that does not move the stored reload bit from 0 to 1 leaves the output waveform unchanged.
- R4: A reload happens only when a write to the integer register moves the stored bit 16 from 0 to 1. Writing a 1 while the stored bit is already 1 starts no reload.
- R5: While a valid set (INT, M, N) is active, every period lasts either INT or INT+1 cycles. Any N consecutive periods together last exactly INT×N+M cycles.
- R6: Each period is high for its first floor(length/2) cycles and low for the remaining cycles.
- R7: If the active set has INT < 2, N = 0, or M ≥ N, clk_out stays low.
- R8: A reloaded set takes effect at the end of the period in progress, which keeps its old length. The accumulator restarts from zero, so the first new period lasts exactly INT cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = fraction (offset 0), 1 = integer (offset 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected shadow register |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds the divider with a 6-bit whole part and 4-bit fraction fields. These narrow widths make an exhaustive fraction sweep affordable: INT runs from 2 to 5, N over every value from 1 to 15, and M over every value below N. In each case the bench sums N consecutive periods and compares the total with INT×N+M, and it checks every period's length and high time. The narrow widths also bring the largest period within reach (INT at 63 with a carry, giving 64 cycles). Further directed sequences check that reload is atomic and happens on the edge only, that a switch occurs at a period boundary with the accumulator cleared, and that each kind of invalid set holds the output low.

// File: rtl/mnfd_pkg.sv
package mnfd_pkg;
  // Register field positions: the bit layout software relies on.
  localparam int REG_W        = 32;
  localparam int FLD_M_LSB    = 0;
  localparam int FLD_N_LSB    = 16;
  localparam int FLD_INT_LSB  = 0;
  localparam int FLD_RLD_BIT  = 16;
  localparam int FLD_MAX_W    = 16;

  typedef enum logic {
    SEL_FRAC = 1'b0,
    SEL_INT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mnfd_regs.sv
module mnfd_regs
  import mnfd_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              take_i,
  output logic              pend_o,
  output logic [INT_W-1:0]  stg_int_o,
  output logic [FRAC_W-1:0] stg_m_o,
  output logic [FRAC_W-1:0] stg_n_o
);
  // Shadow copies seen by software
  logic [INT_W-1:0]  shd_int_q, shd_int_d;
  logic [FRAC_W-1:0] shd_m_q, shd_m_d;
  logic [FRAC_W-1:0] shd_n_q, shd_n_d;
  logic              shd_rld_q, shd_rld_d;
  // Staged set captured on a reload edge, waiting for the engine
  logic [INT_W-1:0]  stg_int_q, stg_int_d;
  logic [FRAC_W-1:0] stg_m_q, stg_m_d;
  logic [FRAC_W-1:0] stg_n_q, stg_n_d;
  logic              pend_q, pend_d;

  logic wr_frac, wr_int, rld_rise;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_comb begin
    wr_frac  = wr_i && (sel_i == SEL_FRAC);
    wr_int   = wr_i && (sel_i == SEL_INT);
    rld_rise = wr_int && wdata_i[FLD_RLD_BIT] && !shd_rld_q;

    shd_m_d   = wr_frac ? wdata_i[FLD_M_LSB +: FRAC_W] : shd_m_q;
    shd_n_d   = wr_frac ? wdata_i[FLD_N_LSB +: FRAC_W] : shd_n_q;
    shd_int_d = wr_int  ? wdata_i[FLD_INT_LSB +: INT_W] : shd_int_q;
    shd_rld_d = wr_int  ? wdata_i[FLD_RLD_BIT] : shd_rld_q;

    stg_int_d = rld_rise ? shd_int_d : stg_int_q;
    stg_m_d   = rld_rise ? shd_m_d   : stg_m_q;
    stg_n_d   = rld_rise ? shd_n_d   : stg_n_q;
    pend_d    = rld_rise || (pend_q && !take_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_int_q <= '0;
      shd_m_q   <= '0;
      shd_n_q   <= '0;
      shd_rld_q <= 1'b0;
      stg_int_q <= '0;
      stg_m_q   <= '0;
      stg_n_q   <= '0;
      pend_q    <= 1'b0;
    end else begin
      shd_int_q <= shd_int_d;
      shd_m_q   <= shd_m_d;
      shd_n_q   <= shd_n_d;
      shd_rld_q <= shd_rld_d;
      stg_int_q <= stg_int_d;
      stg_m_q   <= stg_m_d;
      stg_n_q   <= stg_n_d;
      pend_q    <= pend_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_FRAC) begin
      rdata_o[FLD_M_LSB +: FRAC_W] = shd_m_q;
      rdata_o[FLD_N_LSB +: FRAC_W] = shd_n_q;
    end else begin
      rdata_o[FLD_INT_LSB +: INT_W] = shd_int_q;
      rdata_o[FLD_RLD_BIT]          = shd_rld_q;
    end
  end

  assign pend_o    = pend_q;
  assign stg_int_o = stg_int_q;
  assign stg_m_o   = stg_m_q;
  assign stg_n_o   = stg_n_q;

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(shd_int_q) && $stable(shd_m_q) && $stable(shd_n_q) && $stable(shd_rld_q)));

  // R4
  reload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(wr_i && (sel_i == SEL_INT) && wdata_i[FLD_RLD_BIT]));

  // R4
  held_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && shd_rld_q && wr_i && (sel_i == SEL_INT)) |=> !pend_q);
endmodule

// File: rtl/mnfd_engine.sv
module mnfd_engine #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_i,
  input  logic [INT_W-1:0]  stg_int_i,
  input  logic [FRAC_W-1:0] stg_m_i,
  input  logic [FRAC_W-1:0] stg_n_i,
  output logic              take_o,
  output logic              clk_o
);
  localparam int LEN_W = INT_W + 1;
  localparam int SUM_W = FRAC_W + 1;

  // Active set
  logic [INT_W-1:0]  act_int_q, act_int_d;
  logic [FRAC_W-1:0] act_m_q, act_m_d;
  logic [FRAC_W-1:0] act_n_q, act_n_d;
  logic              act_ok_q, act_ok_d;
  // Period state
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              out_q, out_d;

  logic              at_end, take, nx_ok, carry;
  logic [INT_W-1:0]  nx_int;
  logic [FRAC_W-1:0] nx_m, nx_n, acc_base;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    at_end = !act_ok_q || (cnt_q == (len_q - LEN_W'(1)));
    take   = at_end && pend_i;

    nx_int = take ? stg_int_i : act_int_q;
    nx_m   = take ? stg_m_i   : act_m_q;
    nx_n   = take ? stg_n_i   : act_n_q;
    nx_ok  = (nx_int >= INT_W'(2)) && (nx_n != '0) && (nx_m < nx_n);

    acc_base = take ? '0 : acc_q;
    sum      = SUM_W'(acc_base) + SUM_W'(nx_m);
    carry    = (sum >= SUM_W'(nx_n));

    act_int_d = nx_int;
    act_m_d   = nx_m;
    act_n_d   = nx_n;

    acc_d    = acc_q;
    len_d    = len_q;
    cnt_d    = cnt_q + LEN_W'(1);
    act_ok_d = act_ok_q;

    if (at_end) begin
      act_ok_d = nx_ok;
      cnt_d    = '0;
      if (nx_ok) begin
        len_d = LEN_W'(nx_int) + LEN_W'(carry);
        acc_d = carry ? FRAC_W'(sum - SUM_W'(nx_n)) : FRAC_W'(sum);
      end else begin
        len_d = '0;
        acc_d = '0;
      end
    end

    out_d = act_ok_d && (cnt_d < (len_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_int_q <= '0;
      act_m_q   <= '0;
      act_n_q   <= '0;
      act_ok_q  <= 1'b0;
      acc_q     <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      out_q     <= 1'b0;
    end else begin
      act_int_q <= act_int_d;
      act_m_q   <= act_m_d;
      act_n_q   <= act_n_d;
      act_ok_q  <= act_ok_d;
      acc_q     <= acc_d;
      len_q     <= len_d;
      cnt_q     <= cnt_d;
      out_q     <= out_d;
    end
  end

  assign take_o = take;
  assign clk_o  = out_q;

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_ok_q |-> !clk_o);

  // R5
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok_q |-> (acc_q < act_n_q));

  // R5
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok_q |-> ((len_q == LEN_W'(act_int_q)) || (len_q == LEN_W'(act_int_q) + LEN_W'(1))));

  // R6
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ok_q && (cnt_q == '0)) |-> clk_o);

  // R8
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ok_q && (cnt_q != (len_q - LEN_W'(1))))
      |=> ($stable(act_int_q) && $stable(act_m_q) && $stable(act_n_q)));
endmodule

// File: rtl/mn_frac_clkdiv.sv
module mn_frac_clkdiv
  import mnfd_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        clk_out
);
  logic              pend, take;
  logic [INT_W-1:0]  stg_int;
  logic [FRAC_W-1:0] stg_m, stg_n;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_sel);

  mnfd_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .sel_i    (sel),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .take_i   (take),
    .pend_o   (pend),
    .stg_int_o(stg_int),
    .stg_m_o  (stg_m),
    .stg_n_o  (stg_n)
  );

  mnfd_engine #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .stg_int_i(stg_int),
    .stg_m_i  (stg_m),
    .stg_n_i  (stg_n),
    .take_o   (take),
    .clk_o    (clk_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !clk_out);
endmodule

// File: tb/mn_frac_clkdiv_bench.sv
module mn_frac_clkdiv_bench;
  localparam int INT_W  = 6;
  localparam int FRAC_W = 4;
  localparam logic [31:0] RLD = 32'h0001_0000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        clk_out;

  int n_chk;
  int n_fail;
  bit fin;

  mn_frac_clkdiv #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_mn_frac_clkdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .clk_out  (clk_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input bit s, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic program_set(input int i, input int m, input int n, input bit keep);
    wr(1'b0, (32'(n) << 16) | 32'(m));
    wr(1'b1, 32'(i) | RLD);
    if (!keep) wr(1'b1, 32'(i));
  endtask

  task automatic wait_rise();
    bit last;
    last = clk_out;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      if (clk_out && !last) return;
      last = clk_out;
    end
    check(1'b0, "R5", "no rising edge seen", 0, 1);
  endtask

  task automatic measure(output int len, output int hi);
    bit last;
    len = 1; hi = 1; last = 1'b1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      if (clk_out && !last) return;
      len++;
      if (clk_out) hi++;
      last = clk_out;
    end
    check(1'b0, "R5", "period never ended", len, 0);
  endtask

  task automatic count_high(input int cyc, output int hi);
    hi = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (clk_out) hi++;
    end
  endtask

  // Sum of p periods with per-period length and high-time checks
  task automatic run_periods(input int i, input int p, output int sum, output int bad_len,
                             output int bad_hi);
    int len, hi;
    sum = 0; bad_len = 0; bad_hi = 0;
    for (int k = 0; k < p; k++) begin
      measure(len, hi);
      sum += len;
      if (len != i && len != i + 1) bad_len++;
      if (hi != len / 2) bad_hi++;
    end
  endtask

  initial begin
    fin = 1'b0;
    repeat (200000) @(posedge clk);
    if (!fin) begin
      check(1'b0, "R5", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int sum, bl, bh, l1, l2, l3, h1, hi;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(1'b0, d); check(d == 0, "R1", "fraction reg after reset", d, 0);
    rd(1'b1, d); check(d == 0, "R1", "integer reg after reset", d, 0);
    count_high(20, hi); check(hi == 0, "R1", "clk_out high cycles after reset", hi, 0);

    // R5/R6: sweep of every fraction for several whole parts
    for (int i = 2; i <= 5; i++) begin
      for (int n = 1; n <= 15; n++) begin
        for (int m = 0; m < n; m++) begin
          program_set(i, m, n, 1'b0);
          wait_rise();
          run_periods(i, n, sum, bl, bh);
          check(sum == i * n + m, "R5", $sformatf("N-period total i=%0d m=%0d n=%0d", i, m, n),
                sum, i * n + m);
          check(bl == 0, "R5", "periods outside INT..INT+1", bl, 0);
          check(bh == 0, "R6", "periods with wrong high time", bh, 0);
        end
      end
    end

    // R5/R6: largest whole part, with carry reaching a 64-cycle period
    program_set(63, 14, 15, 1'b0);
    wait_rise();
    run_periods(63, 15, sum, bl, bh);
    check(sum == 63 * 15 + 14, "R5", "max INT total", sum, 63 * 15 + 14);
    check(bl == 0, "R5", "max INT period range", bl, 0);
    check(bh == 0, "R6", "max INT high time", bh, 0);

    // R8: switch at the period boundary, accumulator cleared
    program_set(5, 0, 1, 1'b0);
    wait_rise(); wait_rise();
    wr(1'b0, (32'd3 << 16) | 32'd2);
    wait_rise();
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'd3 | RLD;
    measure(l1, h1);
    measure(l2, h1);
    measure(l3, h1);
    check(l1 == 5, "R8", "period holding the reload keeps old length", l1, 5);
    check(l2 == 3, "R8", "first new period equals INT", l2, 3);
    check(l3 == 4, "R8", "second new period carries", l3, 4);
    wr(1'b1, 32'd3);

    // R3: writes without a reload edge do not change the output; R2 readback
    wr(1'b0, (32'd2 << 16) | 32'd1);
    wr(1'b1, 32'd6);
    rd(1'b0, d); check(d == ((32'd2 << 16) | 32'd1), "R2", "fraction readback", d, (2 << 16) | 1);
    rd(1'b1, d); check(d == 32'd6, "R2", "integer readback", d, 6);
    wait_rise();
    run_periods(3, 3, sum, bl, bh);
    check(sum == 11, "R3", "old set still running after plain writes", sum, 11);

    // R4: reload bit held high does not reload
    program_set(4, 0, 1, 1'b1);
    wait_rise(); wait_rise();
    rd(1'b1, d); check(d == (32'd4 | RLD), "R2", "reload bit reads back set", d, 4 | RLD);
    wr(1'b1, 32'd7 | RLD);
    wait_rise();
    run_periods(4, 3, sum, bl, bh);
    check(sum == 12, "R4", "held reload bit started no reload", sum, 12);
    rd(1'b1, d); check(d == (32'd7 | RLD), "R2", "integer readback with reload", d, 7 | RLD);
    wr(1'b1, 32'd7);
    rd(1'b1, d); check(d == 32'd7, "R2", "reload bit reads back clear", d, 7);
    wr(1'b1, 32'd7 | RLD);
    wait_rise(); wait_rise();
    run_periods(7, 3, sum, bl, bh);
    check(sum == 21, "R4", "fresh 0-to-1 edge reloads", sum, 21);
    wr(1'b1, 32'd7);

    // R7: invalid sets hold the output low
    program_set(1, 0, 1, 1'b0);
    repeat (80) @(negedge clk);
    count_high(100, hi); check(hi == 0, "R7", "INT=1 output high cycles", hi, 0);
    program_set(0, 0, 1, 1'b0);
    repeat (10) @(negedge clk);
    count_high(100, hi); check(hi == 0, "R7", "INT=0 output high cycles", hi, 0);
    program_set(4, 0, 1, 1'b0);
    wait_rise();
    run_periods(4, 2, sum, bl, bh);
    check(sum == 8, "R7", "valid set resumes after invalid", sum, 8);
    program_set(4, 0, 0, 1'b0);
    repeat (20) @(negedge clk);
    count_high(100, hi); check(hi == 0, "R7", "N=0 output high cycles", hi, 0);
    program_set(4, 0, 1, 1'b0);
    wait_rise();
    program_set(4, 3, 3, 1'b0);
    repeat (20) @(negedge clk);
    count_high(100, hi); check(hi == 0, "R7", "M=N output high cycles", hi, 0);

    fin = 1'b1;
    summary();
  end
endmodule